// File: doc/BRIEF.md
# UART Transmitter with Line-Break Sequencing

This block is the transmit half of a serial port. Bytes written into a four-entry queue are sent as asynchronous frames: one low start bit, eight data bits with the least significant bit first, and one high stop bit. An external baud tick marks each bit-period boundary, so the block never divides the clock itself. A 32-bit control word, written through a simple write strobe and always visible on a readback bus, gates the transmitter on and off and requests a line break.

A break request waits until every queued byte and the frame in the shifter have left the line. The line is then driven low. It stays low until a stop request arrives and at least one full character time of low has elapsed. After that, a high guard interval of twelve bit periods runs before queued data may flow again. The start and stop request bits interlock, so a break can only be armed while the stop bit is clear.

Top module: `uart_brk_tx`

## Requirements
- R1: The control word reads back as 0x128 after reset, with the line high and `busy` low. Its fields are: bit 8 stop-break, bit 7 start-break, bit 5 transmit-off, bit 4 transmit-on, and bit 3 a stored receive-off flag. All other bits read as zero.
- R2: Each byte goes out as a 10-bit frame: a low start bit, then data bits 0 to 7 in order, then a high stop bit. Each bit lasts exactly one baud-tick interval. A queued byte starts at the tick that follows the stop bit, with no idle gap. The line changes only on a clock edge at which `baudTick` is high.
- R3: The transmitter loads new frames only while bit 4 is 1 and bit 5 is 0, so transmit-off wins over transmit-on. While it is off, the line idles high and queued bytes stay in the queue. A frame that has already started still completes.
- R4: After start-break is armed, every byte queued before and during the wait is sent first. The line drives low at the second tick after the final stop bit, which leaves one idle-high period in between.
- R5: A write with bit 7 set arms start-break only if the stored stop-break bit is currently 0. Writing bit 7 as 0 leaves start-break unchanged.
- R6: A write with bit 8 set is always accepted, and it clears start-break in the same write.
- R7: Once the low phase has begun, it lasts at least 10 bit periods, even if stop-break arrives earlier. It ends at the first tick at which stop-break is already stored and that minimum has been met.
- R8: When the break ends, the line stays high for exactly 12 bit periods. Bytes queued during the break then start at the next tick, and start-break reads back as 0.
- R9: `busy` is high while the queue holds data, a frame is shifting, or a break sequence (drain wait, low phase or guard) is in progress.
- R10: The queue holds 4 bytes. `fifoFull` rises when it is full, and a byte written while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 32 | Control word write value |
| regRdData | output | 32 | Current control word |
| fifoWrEn | input | 1 | Queue write strobe |
| fifoWrData | input | 8 | Byte to queue |
| fifoFull | output | 1 | Queue holds 4 bytes |
| baudTick | input | 1 | One-cycle pulse per bit period |
| txOut | output | 1 | Serial line |
| busy | output | 1 | Data pending or break sequence running |

## Verification
Two events can land on the same clock edge: a control write that sets stop-break, and the baud tick that could end the low phase. The bench drives both in one cycle once the minimum low time has already passed. It expects the stored stop bit to be seen only at the following tick, giving exactly 15 low periods instead of 14. The interlock is also provoked on one edge, with a single write that sets start-break while clearing a stop-break that was set before. The readback must show start-break still clear.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_LOW   = 2'd2,
    SEQ_GUARD = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadOk;   // shifter may pull a new byte at the next tick
    logic lineLow;  // force the serial line low
  } txStrobe_t;

  localparam int BIT_STOP  = 8;
  localparam int BIT_START = 7;
  localparam int BIT_TXOFF = 5;
  localparam int BIT_TXON  = 4;
  localparam int BIT_RXOFF = 3;

endpackage

// File: rtl/ubt_ctrl.sv
module ubt_ctrl
  import ubt_pkg::*;
#(
  parameter int CHAR_BITS  = 10,
  parameter int GUARD_BITS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        baudTick,
  input  logic        drained,
  output txStrobe_t   strobe,
  output logic        inSeq
);

  localparam int LCW = $clog2(CHAR_BITS);
  localparam int GCW = $clog2(GUARD_BITS);
  localparam logic [LCW-1:0] LOW_LAST   = LCW'(CHAR_BITS - 1);
  localparam logic [GCW-1:0] GUARD_LAST = GCW'(GUARD_BITS - 2);

  logic stopBrk, startBrk, txOff, txOn, rxOff;
  seqState_t state;
  logic [LCW-1:0] lowCnt;
  logic [GCW-1:0] guardCnt;
  logic seqDone;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[31:9], regWrData[6], regWrData[2:0]};
  assign seqDone = (state == SEQ_GUARD) && baudTick && (guardCnt == GUARD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopBrk  <= 1'b1;
      startBrk <= 1'b0;
      txOff    <= 1'b1;
      txOn     <= 1'b0;
      rxOff    <= 1'b1;
      state    <= SEQ_RUN;
      lowCnt   <= '0;
      guardCnt <= '0;
    end else begin
      if (seqDone) startBrk <= 1'b0;
      if (regWrEn) begin
        stopBrk <= regWrData[BIT_STOP];
        txOff   <= regWrData[BIT_TXOFF];
        txOn    <= regWrData[BIT_TXON];
        rxOff   <= regWrData[BIT_RXOFF];
        if (regWrData[BIT_STOP]) startBrk <= 1'b0;
        else if (regWrData[BIT_START] && !stopBrk) startBrk <= 1'b1;
      end
      case (state)
        SEQ_RUN: if (startBrk) state <= SEQ_DRAIN;
        SEQ_DRAIN: begin
          if (!startBrk) state <= SEQ_RUN;
          else if (baudTick && drained) begin
            state  <= SEQ_LOW;
            lowCnt <= '0;
          end
        end
        SEQ_LOW: begin
          if (baudTick) begin
            if (stopBrk && lowCnt == LOW_LAST) begin
              state    <= SEQ_GUARD;
              guardCnt <= '0;
            end else if (lowCnt != LOW_LAST) begin
              lowCnt <= lowCnt + 1'b1;
            end
          end
        end
        SEQ_GUARD: begin
          if (baudTick) begin
            if (guardCnt == GUARD_LAST) state <= SEQ_RUN;
            else guardCnt <= guardCnt + 1'b1;
          end
        end
        default: state <= SEQ_RUN;
      endcase
    end
  end

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_STOP]  = stopBrk;
    regRdData[BIT_START] = startBrk;
    regRdData[BIT_TXOFF] = txOff;
    regRdData[BIT_TXON]  = txOn;
    regRdData[BIT_RXOFF] = rxOff;
  end

  assign strobe.loadOk  = txOn && !txOff && (state == SEQ_RUN || state == SEQ_DRAIN);
  assign strobe.lineLow = (state == SEQ_LOW);
  assign inSeq          = (state != SEQ_RUN);

endmodule

// File: rtl/ubt_datapath.sv
module ubt_datapath
  import ubt_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoWrEn,
  input  logic [DATA_W-1:0] fifoWrData,
  input  logic              baudTick,
  input  txStrobe_t         strobe,
  output logic              txOut,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              shiftActive,
  output logic              popStrobe
);

  localparam int AW = $clog2(DEPTH);
  localparam int FW = DATA_W + 2;
  localparam int BCW = $clog2(FW);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   LVL_FULL = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] level;
  logic [FW-1:0] shReg;
  logic [BCW-1:0] bitCnt;
  logic push, bitsLeft;

  assign fifoFull  = (level == LVL_FULL);
  assign fifoEmpty = (level == '0);
  assign push      = fifoWrEn && !fifoFull;
  assign bitsLeft  = shiftActive && (bitCnt != '0);
  assign popStrobe = baudTick && strobe.loadOk && !fifoEmpty && !bitsLeft;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= fifoWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (popStrobe) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({push, popStrobe})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg       <= '1;
      bitCnt      <= '0;
      shiftActive <= 1'b0;
    end else if (baudTick) begin
      if (bitsLeft) begin
        shReg  <= {1'b1, shReg[FW-1:1]};
        bitCnt <= bitCnt - 1'b1;
      end else if (popStrobe) begin
        shReg       <= {1'b1, mem[rdPtr], 1'b0};
        bitCnt      <= BCW'(FW - 1);
        shiftActive <= 1'b1;
      end else begin
        shiftActive <= 1'b0;
      end
    end
  end

  assign txOut = strobe.lineLow ? 1'b0 : (shiftActive ? shReg[0] : 1'b1);

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import ubt_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int CHAR_BITS  = 10,
  parameter int GUARD_BITS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        fifoWrEn,
  input  logic [7:0]  fifoWrData,
  output logic        fifoFull,
  input  logic        baudTick,
  output logic        txOut,
  output logic        busy
);

  txStrobe_t strobe;
  logic fifoEmpty, shiftActive, popStrobe, inSeq;

  ubt_ctrl #(.CHAR_BITS(CHAR_BITS), .GUARD_BITS(GUARD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .baudTick(baudTick),
    .drained(fifoEmpty && !shiftActive), .strobe(strobe), .inSeq(inSeq)
  );

  ubt_datapath #(.DEPTH(DEPTH), .DATA_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .baudTick(baudTick), .strobe(strobe), .txOut(txOut), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .shiftActive(shiftActive), .popStrobe(popStrobe)
  );

  assign busy = !fifoEmpty || shiftActive || inSeq;

endmodule

// File: rtl/ubt_checker.sv
module ubt_checker (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic wrStop,
  input logic wrStart,
  input logic rdStop,
  input logic rdStart,
  input logic rdTxOff,
  input logic rdTxOn,
  input logic baudTick,
  input logic txOut,
  input logic busy,
  input logic popStrobe
);

  AST_START_INTERLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && wrStart && !wrStop && rdStop && !rdStart) |=> !rdStart); // R5

  AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && wrStop) |=> (rdStop && !rdStart)); // R6

  AST_NO_POP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !(rdTxOn && !rdTxOff) |-> !popStrobe); // R3

  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(baudTick) |-> $stable(txOut)); // R2

  AST_QUIET_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut); // R9

endmodule

bind uart_brk_tx ubt_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
  .wrStop(regWrData[8]), .wrStart(regWrData[7]),
  .rdStop(regRdData[8]), .rdStart(regRdData[7]),
  .rdTxOff(regRdData[5]), .rdTxOn(regRdData[4]),
  .baudTick(baudTick), .txOut(txOut), .busy(busy), .popStrobe(popStrobe)
);

// File: tb/sim_uart_brk_tx.sv
module sim_uart_brk_tx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic fifoWrEn = 1'b0;
  logic [7:0] fifoWrData = '0;
  logic fifoFull;
  logic baudTick = 1'b0;
  logic txOut;
  logic busy;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_brk_tx u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoFull(fifoFull), .baudTick(baudTick), .txOut(txOut), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); fifoWrEn = 1'b1; fifoWrData = b;
    @(negedge clk); fifoWrEn = 1'b0;
  endtask

  task automatic period();
    @(negedge clk); baudTick = 1'b1;
    @(negedge clk); baudTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic periodWr(input logic [31:0] d);
    @(negedge clk); baudTick = 1'b1; regWrEn = 1'b1; regWrData = d;
    @(negedge clk); baudTick = 1'b0; regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectLine(input logic exp, input string tag);
    chk(txOut === exp, tag, 32'(txOut), 32'(exp));
  endtask

  task automatic expectFrame(input logic [7:0] b, input string tag);
    for (int i = 0; i < 10; i++) begin
      period();
      expectLine((i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1], tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(regRdData == 32'h128, "R1 reset word", regRdData, 32'h128);
    expectLine(1'b1, "R1 reset line");
    chk(busy == 1'b0, "R1 reset busy", 32'(busy), 0);

    // R3 on+off both set: off wins, byte stays queued
    regWr(32'h138);
    push(8'hA5);
    for (int i = 0; i < 12; i++) begin
      period();
      expectLine(1'b1, "R3 off line idle");
    end
    chk(busy == 1'b1, "R3 byte kept / R9 busy", 32'(busy), 1);
    regWr(32'h110);
    expectFrame(8'hA5, "R3 released byte");
    period();
    expectLine(1'b1, "R2 idle after frame");
    chk(busy == 1'b0, "R9 idle busy", 32'(busy), 0);

    // R2 sweep every byte value, back to back
    for (int v = 0; v < 256; v++) begin
      push(8'(v));
      expectFrame(8'(v), "R2 frame");
    end
    period();
    chk(busy == 1'b0, "R9 after sweep", 32'(busy), 0);

    // R10 queue depth and overflow drop
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    chk(fifoFull == 1'b1, "R10 full flag", 32'(fifoFull), 1);
    push(8'h55);
    expectFrame(8'h11, "R10 q0");
    expectFrame(8'h22, "R10 q1");
    expectFrame(8'h33, "R10 q2");
    expectFrame(8'h44, "R10 q3");
    period();
    expectLine(1'b1, "R10 dropped byte not sent");
    chk(busy == 1'b0, "R10 queue empty", 32'(busy), 0);

    // R3 turn off mid-frame: frame finishes, next byte held
    push(8'h3C); push(8'h5A);
    period();
    expectLine(1'b0, "R3 start bit");
    regWr(32'h130);
    for (int i = 1; i < 10; i++) begin
      period();
      expectLine((i == 9) ? 1'b1 : 1'(8'h3C >> (i - 1)), "R3 frame completes");
    end
    for (int i = 0; i < 5; i++) begin
      period();
      expectLine(1'b1, "R3 held while off");
    end
    chk(busy == 1'b1, "R3 second byte kept", 32'(busy), 1);
    regWr(32'h110);
    expectFrame(8'h5A, "R3 held byte");
    period();

    // R5 interlock: start with stop currently set is refused
    regWr(32'h090);
    chk(regRdData == 32'h010, "R5 start refused", regRdData, 32'h010);
    push(8'h81); push(8'h7E);
    regWr(32'h090);
    chk(regRdData == 32'h090, "R5 start armed", regRdData, 32'h090);
    regWr(32'h010);
    chk(regRdData == 32'h090, "R5 zero write keeps start", regRdData, 32'h090);

    // R4 break waits for queued data
    expectFrame(8'h81, "R4 drain byte 0");
    expectFrame(8'h7E, "R4 drain byte 1");
    period();
    expectLine(1'b1, "R4 idle before break");
    for (int i = 0; i < 3; i++) begin
      period();
      expectLine(1'b0, "R4 break low");
    end
    regWr(32'h110);
    chk(regRdData == 32'h110, "R6 stop clears start", regRdData, 32'h110);
    push(8'hC3);
    for (int i = 3; i < 10; i++) begin
      period();
      expectLine(1'b0, "R7 minimum low");
    end
    for (int i = 0; i < 12; i++) begin
      period();
      expectLine(1'b1, "R8 guard high");
    end
    chk(busy == 1'b1, "R9 busy in guard", 32'(busy), 1);
    chk(regRdData[7] == 1'b0, "R8 start clear after", 32'(regRdData[7]), 0);
    expectFrame(8'hC3, "R8 resume after guard");
    period();

    // R7 late stop written in the same cycle as a tick
    regWr(32'h010);
    regWr(32'h090);
    for (int i = 0; i < 14; i++) begin
      period();
      expectLine(1'b0, "R7 held low");
    end
    periodWr(32'h110);
    expectLine(1'b0, "R7 stop seen next tick");
    for (int i = 0; i < 12; i++) begin
      period();
      expectLine(1'b1, "R8 guard after late stop");
    end
    chk(busy == 1'b0, "R9 done after guard", 32'(busy), 0);
    chk(regRdData == 32'h110, "R8 word after break", regRdData, 32'h110);
    period();
    expectLine(1'b1, "R8 idle after guard");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule